// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and a slower memory port. Word stores from the processor side are absorbed into a small set of rows, each of which covers one whole cache line and keeps a valid bit per word. A store to a line that already owns a row is merged into that row. A store to a new line claims a free row. The processor side stalls only when every row is taken and the store cannot merge.

On the memory side, a single ready/valid port drains one complete line per transfer. It carries the line address, all word lanes, and a per-word mask so that memory updates only the words that were written. Rows drain oldest first. A drain begins in three cases: the buffer is full, the cache controller raises an explicit push-out request, or a read has to wait for a row. While a row is being sent it is closed to further merges.

The cache controller probes the buffer by line address before it sends a read miss to memory. It gets back one of three answers. A complete line is forwarded straight from the buffer. A wait is returned when the line is only partly valid or is already on its way out. A go-ahead to memory is returned when no row holds the line. While that go-ahead stands, no new drain is started, so the read miss has the memory port first.

Top module: `wbuf_merge`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` is 1, `mem_valid` is 0, and a lookup of any line returns `rd_mem`=1.
- R2: An accepted store (`wr_valid` and `wr_ready` high at a clock edge) to a line held by no open row claims a new row. The line address is `wr_addr[AW-1:2]` and the word index is `wr_addr[1:0]` (for 4 words per line). Only the written word becomes valid.
- R3: An accepted store to a line held by an open row (one not being drained) merges into that row, setting its word's valid bit and replacing that word. No second row is used, and the merge is accepted even when every row is occupied.
- R4: `wr_ready` is 0 only when every row is occupied and no open row holds the store's line.
- R5: A drain transfer starts when all rows are occupied, when `drain_req` is 1, or when a lookup returns `rd_wait`. Rows leave oldest first, one per transfer. `mem_valid`, `mem_addr`, `mem_data` and `mem_mask` hold steady until `mem_ready` is seen.
- R6: `mem_mask` bit k is 1 exactly when word k of the row was written since the row was claimed. Word k occupies `mem_data[k*DW +: DW]` and carries the latest value written to it.
- R7: A row being drained accepts no merge. A store to its line goes to another open row of that line, or claims a fresh row.
- R8: A lookup (`rd_valid`, line `rd_addr`) that finds an open row with all words valid gives `rd_hit`=1 and that row's data on `rd_line`. The lookup sees the buffer as it stood at the start of the cycle.
- R9: A lookup that matches only a partly valid row, or that matches the row being drained, gives `rd_wait`=1.
- R10: A lookup that matches no row gives `rd_mem`=1. While it stands, no new drain transfer starts; a transfer already under way continues.
- R11: With fewer than all rows occupied, `drain_req` low and no waiting lookup, no drain starts and buffered rows stay put.
- R12: The three lookup flags are all 0 when `rd_valid` is 0, and exactly one is 1 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store can be taken this cycle |
| wr_addr | input | AW (16) | Word address of the store |
| wr_data | input | DW (32) | Store data |
| drain_req | input | 1 | Ask for buffered lines to be pushed out |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | AW-2 (14) | Line address to look up |
| rd_hit | output | 1 | Whole line available from the buffer |
| rd_wait | output | 1 | Line present but not usable yet; retry after drain |
| rd_mem | output | 1 | Line not buffered; memory may be read |
| rd_line | output | WORDS*DW (128) | Forwarded line on a hit |
| mem_valid | output | 1 | Drain transfer offered |
| mem_ready | input | 1 | Memory takes the transfer |
| mem_addr | output | AW-2 (14) | Line address of the drained row |
| mem_data | output | WORDS*DW (128) | Line data of the drained row |
| mem_mask | output | WORDS (4) | Valid words of the drained row |

## Verification
The bench builds the block with its defaults: four rows of four 32-bit words. It confines stores and lookups to a pool of six line addresses. Because the pool is so small, random traffic keeps reaching the full-buffer stall, merges into a full buffer, and stores or lookups aimed at the row being drained. Random memory backpressure holds transfers for several cycles, which exercises the stability rule and the lookup-over-drain priority while a transfer is pending.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    LK_NONE = 2'd0,
    LK_MEM  = 2'd1,
    LK_HIT  = 2'd2,
    LK_WAIT = 2'd3
  } lookup_e;
endpackage

// File: rtl/wbuf_row_store.sv
module wbuf_row_store #(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int LAW   = 14,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LW    = WORDS * DW
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_new,
  input  logic [PTR_W-1:0]                wr_row,
  input  logic [OFF_W-1:0]                wr_word,
  input  logic [LAW-1:0]                  wr_tag,
  input  logic [DW-1:0]                   wr_data,
  output logic [DEPTH-1:0][LAW-1:0]       row_tag,
  output logic [DEPTH-1:0][WORDS-1:0]     row_mask,
  output logic [DEPTH-1:0][LW-1:0]        row_data
);

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic             row_we;
    logic [LAW-1:0]   tag_q, tag_d;
    logic [WORDS-1:0] mask_q, mask_d, word_sel;

    always_comb begin
      row_we   = wr_en && (wr_row == PTR_W'(r));
      word_sel = WORDS'(1) << wr_word;
      tag_d    = wr_new ? wr_tag : tag_q;
      mask_d   = wr_new ? word_sel : (mask_q | word_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q  <= '0;
        mask_q <= '0;
      end else if (row_we) begin
        tag_q  <= tag_d;
        mask_q <= mask_d;
      end
    end

    assign row_tag[r]  = tag_q;
    assign row_mask[r] = mask_q;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DW-1:0] word_q;
      logic          word_we;

      always_comb word_we = row_we && (wr_word == OFF_W'(w));

      always_ff @(posedge clk) begin
        if (word_we) word_q <= wr_data;
      end

      assign row_data[r][w*DW +: DW] = word_q;
    end
  end

endmodule

// File: rtl/wbuf_line_match.sv
module wbuf_line_match #(
  parameter int DEPTH = 4,
  parameter int LAW   = 14,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DEPTH-1:0][LAW-1:0] row_tag,
  input  logic [DEPTH-1:0]          occ,
  input  logic                      busy,
  input  logic [PTR_W-1:0]          head,
  input  logic [LAW-1:0]            wr_tag,
  input  logic [LAW-1:0]            rd_tag,
  output logic [DEPTH-1:0]          wr_hit,
  output logic [DEPTH-1:0]          rd_match
);

  for (genvar r = 0; r < DEPTH; r++) begin : g_cmp
    logic sending;
    always_comb begin
      sending     = busy && (head == PTR_W'(r));
      wr_hit[r]   = occ[r] && !sending && (row_tag[r] == wr_tag);
      rd_match[r] = occ[r] && (row_tag[r] == rd_tag);
    end
  end

  // R3: at most one open row owns any line
  p_single_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

endmodule

// File: rtl/wbuf_drain_ctl.sv
module wbuf_drain_ctl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             want,
  input  logic             block,
  input  logic             mem_ready,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [DEPTH-1:0] occ,
  output logic             busy,
  output logic             full
);

  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] occ_q, occ_d;
  logic             busy_q, busy_d;
  logic             start, pop;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    start  = !busy_q && (cnt_q != '0) && want && !block;
    pop    = busy_q && mem_ready;
    busy_d = start ? 1'b1 : (pop ? 1'b0 : busy_q);
    head_d = pop   ? step_ptr(head_q) : head_q;
    tail_d = alloc ? step_ptr(tail_q) : tail_q;
    cnt_d  = cnt_q + CNT_W'(alloc) - CNT_W'(pop);
    occ_d  = occ_q;
    if (pop)   occ_d[head_q] = 1'b0;
    if (alloc) occ_d[tail_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      occ_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      occ_q  <= occ_d;
      busy_q <= busy_d;
    end
  end

  assign head = head_q;
  assign tail = tail_q;
  assign occ  = occ_q;
  assign busy = busy_q;
  assign full = (cnt_q == CNT_W'(DEPTH));

  // R4: occupancy never exceeds the row count and tracks the occupied bits
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(DEPTH)) && ($countones(occ_q) == int'(cnt_q)));
  // R2: a new row is never claimed on top of an occupied one
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !occ_q[tail_q]);
  // R5: an offered transfer stays offered until taken
  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !mem_ready) |=> busy_q);
  // R10: a lookup bound for memory keeps a new transfer from starting
  p_read_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && block) |=> !busy_q);

endmodule

// File: rtl/wbuf_merge.sv
module wbuf_merge
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = 16,
  localparam int OFF_W = $clog2(WORDS),
  localparam int LAW   = AW - OFF_W,
  localparam int LW    = WORDS * DW,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             drain_req,
  input  logic             rd_valid,
  input  logic [LAW-1:0]   rd_addr,
  output logic             rd_hit,
  output logic             rd_wait,
  output logic             rd_mem,
  output logic [LW-1:0]    rd_line,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [LAW-1:0]   mem_addr,
  output logic [LW-1:0]    mem_data,
  output logic [WORDS-1:0] mem_mask
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DEPTH-1:0][LAW-1:0]   row_tag;
  logic [DEPTH-1:0][WORDS-1:0] row_mask;
  logic [DEPTH-1:0][LW-1:0]    row_data;
  logic [DEPTH-1:0]            occ, wr_hit, rd_match;
  logic [PTR_W-1:0]            head, tail, wr_row, hit_row, rd_row;
  logic                        busy, full, merge, accept, alloc;
  logic                        on_drain, want, block;
  logic [LAW-1:0]              wr_tag;
  logic [OFF_W-1:0]            wr_word;
  lookup_e                     lk;

  assign wr_tag  = wr_addr[AW-1:OFF_W];
  assign wr_word = wr_addr[OFF_W-1:0];

  wbuf_line_match #(.DEPTH(DEPTH), .LAW(LAW)) u_match (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .row_tag  (row_tag),
    .occ      (occ),
    .busy     (busy),
    .head     (head),
    .wr_tag   (wr_tag),
    .rd_tag   (rd_addr),
    .wr_hit   (wr_hit),
    .rd_match (rd_match)
  );

  // store side: merge or claim the tail row
  always_comb begin
    hit_row = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_hit[i]) hit_row = PTR_W'(i);
    end
    merge    = |wr_hit;
    wr_ready = !full || merge;
    accept   = wr_valid && wr_ready;
    alloc    = accept && !merge;
    wr_row   = merge ? hit_row : tail;
  end

  wbuf_row_store #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .LAW(LAW)) u_rows (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (accept),
    .wr_new   (alloc),
    .wr_row   (wr_row),
    .wr_word  (wr_word),
    .wr_tag   (wr_tag),
    .wr_data  (wr_data),
    .row_tag  (row_tag),
    .row_mask (row_mask),
    .row_data (row_data)
  );

  // lookup side
  always_comb begin
    rd_row = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_match[i] && !(busy && head == PTR_W'(i))) rd_row = PTR_W'(i);
    end
    on_drain = busy && rd_match[head];
    if (!rd_valid)                                lk = LK_NONE;
    else if (!(|rd_match))                        lk = LK_MEM;
    else if (on_drain || !(&row_mask[rd_row]))    lk = LK_WAIT;
    else                                          lk = LK_HIT;
  end

  assign rd_hit  = (lk == LK_HIT);
  assign rd_wait = (lk == LK_WAIT);
  assign rd_mem  = (lk == LK_MEM);
  assign rd_line = row_data[rd_row];

  // drain arbitration
  assign want  = full || drain_req || rd_wait;
  assign block = rd_mem;

  wbuf_drain_ctl #(.DEPTH(DEPTH)) u_drain (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .alloc     (alloc),
    .want      (want),
    .block     (block),
    .mem_ready (mem_ready),
    .head      (head),
    .tail      (tail),
    .occ       (occ),
    .busy      (busy),
    .full      (full)
  );

  assign mem_valid = busy;
  assign mem_addr  = row_tag[head];
  assign mem_data  = row_data[head];
  assign mem_mask  = row_mask[head];

  // R5: the offered line does not change under backpressure
  p_stable_offer_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask)));
  // R4: a stalled store implies every row is taken
  p_stall_full_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_ready |-> ($countones(occ) == DEPTH));
  // R12: lookup answers are exclusive and present only on request
  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid ? $onehot({rd_hit, rd_wait, rd_mem}) : ({rd_hit, rd_wait, rd_mem} == 3'b000));
  // R9: a waiting lookup gets a transfer going
  p_wait_drains_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_wait && !mem_valid) |=> mem_valid);
  // R11: no trigger, no drain
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mem_valid && wr_ready && !merge && !drain_req && !rd_wait) |=> !mem_valid);
  // R6: an offered row always carries at least one written word
  p_mask_live_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_valid |-> (mem_mask != '0));

endmodule

// File: tb/wbuf_merge_test.sv
module wbuf_merge_test;
  localparam int DEPTH = 4;
  localparam int WORDS = 4;
  localparam int DW    = 32;
  localparam int AW    = 16;
  localparam int OFF_W = 2;
  localparam int LAW   = AW - OFF_W;
  localparam int LW    = WORDS * DW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_valid, drain_req, rd_valid, mem_ready;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;
  logic [LAW-1:0]   rd_addr;
  logic             wr_ready, rd_hit, rd_wait, rd_mem, mem_valid;
  logic [LW-1:0]    rd_line, mem_data;
  logic [LAW-1:0]   mem_addr;
  logic [WORDS-1:0] mem_mask;

  always #5 clk = ~clk;

  wbuf_merge #(.DEPTH(DEPTH), .WORDS(WORDS), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .drain_req(drain_req),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_hit(rd_hit), .rd_wait(rd_wait), .rd_mem(rd_mem), .rd_line(rd_line),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_mask(mem_mask)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // behavioural reference: index 0 is the oldest row
  int             m_n;
  bit             m_busy;
  logic [LAW-1:0] m_tag  [DEPTH];
  logic [WORDS-1:0] m_mask [DEPTH];
  logic [DW-1:0]  m_data [DEPTH][WORDS];

  // values sampled in the last step
  logic s_ready, s_hit, s_wait, s_mem, s_mval;
  logic [LW-1:0] s_line, s_mdata;
  logic [LAW-1:0] s_maddr;
  logic [WORDS-1:0] s_mmask;

  task automatic chk(input string tag, input logic [LW-1:0] got, input logic [LW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input bit wv, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                      input bit rv, input logic [LAW-1:0] ra, input bit dq, input bit mr);
    int mi, ri;
    bit on_d, e_ready, e_hit, e_wait, e_mem, acc, pop, start;
    logic [LAW-1:0] wt;
    logic [LW-1:0] e_line, e_md, em;
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_valid = rv; rd_addr = ra; drain_req = dq; mem_ready = mr;
    #1;
    wt = wa[AW-1:OFF_W];
    mi = -1;
    for (int i = 0; i < m_n; i++)
      if (m_tag[i] == wt && !(m_busy && i == 0)) mi = i;
    e_ready = (m_n < DEPTH) || (mi >= 0);
    ri = -1; on_d = 0;
    for (int i = 0; i < m_n; i++)
      if (m_tag[i] == ra) begin
        if (m_busy && i == 0) on_d = 1; else ri = i;
      end
    e_hit = 0; e_wait = 0; e_mem = 0;
    if (rv) begin
      if (!on_d && ri < 0) e_mem = 1;
      else if (on_d || m_mask[ri] != {WORDS{1'b1}}) e_wait = 1;
      else e_hit = 1;
    end
    s_ready = wr_ready; s_hit = rd_hit; s_wait = rd_wait; s_mem = rd_mem;
    s_mval = mem_valid; s_line = rd_line; s_maddr = mem_addr;
    s_mdata = mem_data; s_mmask = mem_mask;
    chk("R4 wr_ready", LW'(wr_ready), LW'(e_ready));
    chk("R8 rd_hit", LW'(rd_hit), LW'(e_hit));
    chk("R9 rd_wait", LW'(rd_wait), LW'(e_wait));
    chk("R10 rd_mem", LW'(rd_mem), LW'(e_mem));
    if (e_hit) begin
      for (int k = 0; k < WORDS; k++) e_line[k*DW +: DW] = m_data[ri][k];
      chk("R8 rd_line", rd_line, e_line);
    end
    chk("R5 mem_valid", LW'(mem_valid), LW'(m_busy));
    if (m_busy) begin
      chk("R5 mem_addr", LW'(mem_addr), LW'(m_tag[0]));
      chk("R6 mem_mask", LW'(mem_mask), LW'(m_mask[0]));
      for (int k = 0; k < WORDS; k++) begin
        em[k*DW +: DW]   = {DW{m_mask[0][k]}};
        e_md[k*DW +: DW] = m_data[0][k];
      end
      chk("R6 mem_data", mem_data & em, e_md & em);
    end
    // next state of the reference
    acc   = wv && e_ready;
    pop   = m_busy && mr;
    start = !m_busy && (m_n > 0) && ((m_n == DEPTH) || dq || e_wait) && !e_mem;
    if (acc && mi >= 0) begin
      m_mask[mi][wa[OFF_W-1:0]] = 1'b1;
      m_data[mi][wa[OFF_W-1:0]] = wd;
    end
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        m_tag[i] = m_tag[i+1]; m_mask[i] = m_mask[i+1];
        for (int k = 0; k < WORDS; k++) m_data[i][k] = m_data[i+1][k];
      end
      m_n--;
    end
    if (acc && mi < 0) begin
      m_tag[m_n]  = wt;
      m_mask[m_n] = WORDS'(1) << wa[OFF_W-1:0];
      m_data[m_n][wa[OFF_W-1:0]] = wd;
      m_n++;
    end
    m_busy = start ? 1'b1 : (pop ? 1'b0 : m_busy);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] wadr(input int line, input int word);
    return {LAW'(line), OFF_W'(word)};
  endfunction

  task automatic wr(input int line, input int word, input logic [DW-1:0] d);
    step(1, wadr(line, word), d, 0, '0, 0, 0);
  endtask
  task automatic rd(input int line);
    step(0, '0, '0, 1, LAW'(line), 0, 0);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, 0, '0, 0, 0);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_n = 0; m_busy = 0;
    for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_mask[i] = '0; end
    rst_n = 0; wr_valid = 0; wr_addr = '0; wr_data = '0;
    rd_valid = 0; rd_addr = '0; drain_req = 0; mem_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    // R1 reset state
    chk("R1 wr_ready after reset", LW'(s_ready), LW'(1));
    chk("R1 mem_valid after reset", LW'(s_mval), LW'(0));
    rd(12'h33);
    chk("R1 empty lookup goes to memory", LW'(s_mem), LW'(1));
    // R2/R3 claim then merge a whole line
    wr(16, 0, 32'hA0);
    chk("R2 first store accepted", LW'(s_ready), LW'(1));
    for (int k = 1; k < WORDS; k++) wr(16, k, 32'hA0 + k);
    rd(16);
    chk("R3 merged line complete", LW'(s_hit), LW'(1));
    chk("R8 forwarded word 2", LW'(s_line[2*DW +: DW]), LW'(32'hA2));
    idle(4);
    chk("R11 no drain without trigger", LW'(s_mval), LW'(0));
    // R9 partial row forces a drain, oldest first
    wr(17, 1, 32'hC1);
    rd(17);
    chk("R9 partial line waits", LW'(s_wait), LW'(1));
    idle(1);
    chk("R5 oldest row offered", LW'(s_maddr), LW'(16));
    chk("R6 full mask on merged row", LW'(s_mmask), LW'(4'hF));
    // R7 draining row closed to merges
    wr(16, 2, 32'hB2);
    chk("R7 store to draining line takes new row", LW'(s_ready), LW'(1));
    rd(16);
    chk("R7 lookup on draining line waits", LW'(s_wait), LW'(1));
    wr(18, 0, 32'hE0);
    wr(19, 0, 32'hF0);
    chk("R4 stall when full and no match", LW'(s_ready), LW'(0));
    wr(17, 3, 32'hC3);
    chk("R3 merge accepted while full", LW'(s_ready), LW'(1));
    wr(16, 0, 32'hB0);
    chk("R7 merge goes to newer row", LW'(s_ready), LW'(1));
    step(0, '0, '0, 0, '0, 0, 1);
    idle(3);
    chk("R11 rows held below full", LW'(s_mval), LW'(0));
    // R10 read to memory holds off a requested drain
    step(0, '0, '0, 1, LAW'(12'h3F), 1, 0);
    chk("R10 unmatched lookup", LW'(s_mem), LW'(1));
    idle(1);
    chk("R10 drain held back for read", LW'(s_mval), LW'(0));
    step(0, '0, '0, 0, '0, 1, 0);
    idle(1);
    chk("R5 next oldest offered", LW'(s_maddr), LW'(17));
    chk("R6 mask of partial row", LW'(s_mmask), LW'(4'b1010));
    chk("R6 drained word 3", LW'(s_mdata[3*DW +: DW]), LW'(32'hC3));
    rd(20);
    chk("R12 single answer", LW'({s_hit, s_wait, s_mem}), LW'(3'b001));
    for (int i = 0; i < 12; i++) step(0, '0, '0, 0, '0, 1, 1);
    // random traffic on a small line pool
    for (int c = 0; c < 6000; c++) begin
      step(($urandom % 2) == 0, wadr($urandom % 6, $urandom % WORDS), $urandom,
           ($urandom % 4) == 0, LAW'($urandom % 6),
           ($urandom % 10) == 0, ($urandom % 5) < 2);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule